// File: doc/BRIEF.md
# SCSI Byte Staging Latches

This block stages single bytes between a DMA FIFO and a SCSI bus in both directions. On the send side, the DMA logic writes a byte into an output latch. In asynchronous mode that latch drives the bus directly. In synchronous mode the byte first moves into a second output register that software cannot reach, and the bus is driven from there. This gives the synchronous path two stages of storage.

On the receive side, an asynchronously received byte is captured in an input latch and then popped by the DMA side. Synchronously received bytes bypass the latch: the bus handshake and the DMA handshake connect straight through, and the latch stays empty. Each storage stage has its own full flag, and the flags are gathered into a read-only status byte. After an error, software can use that byte to count how many bytes are still held inside the block. A flush input empties every stage in one cycle.

All handshakes use valid/ready: a transfer happens on a rising clock edge where both valid and ready are high. The bus-side protocol timing and the FIFO itself lie outside this block.

Top module: `scsi_byte_stage`

## Requirements
- R1: After reset, status_o is 8'h00, dma_wr_ready_o is 1, and bus_tx_valid_o and dma_rd_valid_o are 0 while no receive byte is offered.
- R2: status_o reports stage occupancy in fixed positions: bit 7 is input-latch-full, bit 6 is hidden-register-full, bit 5 is output-latch-full, and bits 4..0 read 0.
- R3: The output latch accepts a DMA byte only in a cycle that begins with the latch empty (dma_wr_ready_o = 1 exactly then). An accepted byte sets output-latch-full from the next cycle, and a held byte is never overwritten.
- R4: In asynchronous mode (sync_mode_i = 0), bus_tx_valid_o/bus_tx_data_o come directly from the output latch when the hidden register is empty. The hidden register is never loaded in this mode.
- R5: In synchronous mode (sync_mode_i = 1), a byte in the output latch moves into the hidden register on the edge where the hidden register is empty or is being sent, and the bus is driven only from the hidden register. A send and a hand-off can happen on the same edge, so the two bytes leave on consecutive cycles.
- R6: While the hidden register is full, it drives the bus in either mode, ahead of any byte in the output latch.
- R7: In asynchronous mode, a bus byte is captured into the input latch only when the latch is empty (bus_rx_ready_o = 1 exactly then). The DMA side then sees it on dma_rd_valid_o/dma_rd_data_o until it is popped.
- R8: In synchronous mode with the input latch empty, dma_rd_valid_o and dma_rd_data_o follow bus_rx_valid_i and bus_rx_data_i in the same cycle, bus_rx_ready_o equals dma_rd_ready_i, and input-latch-full stays 0. A byte left in the latch from asynchronous mode is delivered first.
- R9: A flush clears all three full flags on the next edge and discards any byte offered to a stage in that cycle.
- R10: Bytes leave each direction in the order in which they entered, with no byte lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| flush_i | input | 1 | Empty all stages on the next edge |
| sync_mode_i | input | 1 | 1 = synchronous transfers, 0 = asynchronous |
| dma_wr_valid_i | input | 1 | DMA side offers a byte to send |
| dma_wr_data_i | input | DATA_W | Byte to send |
| dma_wr_ready_o | output | 1 | Output latch can accept a byte |
| bus_tx_valid_o | output | 1 | A byte is presented to the bus |
| bus_tx_data_o | output | DATA_W | Byte presented to the bus |
| bus_tx_ready_i | input | 1 | Bus takes the presented byte |
| bus_rx_valid_i | input | 1 | Bus offers a received byte |
| bus_rx_data_i | input | DATA_W | Received byte |
| bus_rx_ready_o | output | 1 | Block accepts the received byte |
| dma_rd_valid_o | output | 1 | A received byte is available to the DMA side |
| dma_rd_data_o | output | DATA_W | Received byte for the DMA side |
| dma_rd_ready_i | input | 1 | DMA side pops the received byte |
| status_o | output | 8 | Stage occupancy flags |

## Verification
The bench targets the same-edge hand-off in synchronous mode. A design that waits for the hidden register to drain before refilling it leaves a bubble between two queued bytes. A design that refills while still full overwrites the byte being sent.

It toggles the mode while the hidden register holds a byte. A design that switches the bus to the output latch at once sends the bytes out of order or drops one.

It offers receive bytes with the DMA side stalled. This catches a latch that gets overwritten when full, and a synchronous path that sets the input flag or buffers data it should pass straight through.

Flushes arrive while writes and receives are in flight. This exposes any stage that keeps a byte captured in the flush cycle.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  localparam int STAT_W = 8;

  typedef struct packed {
    logic       in_full;
    logic       hid_full;
    logic       out_full;
    logic [4:0] zero;
  } stage_status_t;
endpackage

// File: rtl/sbs_hold_stage.sv
module sbs_hold_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         load_i,
  input  logic         unload_i,
  input  logic [W-1:0] d_i,
  output logic         full_o,
  output logic [W-1:0] q_o
);
  logic         full_n;
  logic [W-1:0] q_n;

  always_comb begin
    full_n = full_o;
    q_n    = q_o;
    if (clr_i) begin
      full_n = 1'b0;
    end else if (load_i) begin
      full_n = 1'b1;
      q_n    = d_i;
    end else if (unload_i) begin
      full_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_o <= 1'b0;
      q_o    <= '0;
    end else begin
      full_o <= full_n;
      q_o    <= q_n;
    end
  end

  // R3: a stage is loaded only when empty or emptying on the same edge
  a_r3_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !clr_i) |-> (!full_o || unload_i));
endmodule

// File: rtl/sbs_tx_path.sv
module sbs_tx_path #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush_i,
  input  logic         sync_i,
  input  logic         wr_valid_i,
  input  logic [W-1:0] wr_data_i,
  output logic         wr_ready_o,
  output logic         tx_valid_o,
  output logic [W-1:0] tx_data_o,
  input  logic         tx_ready_i,
  output logic         out_full_o,
  output logic         hid_full_o
);
  logic [W-1:0] out_q, hid_q;
  logic         out_load, out_unload, hid_load, hid_unload, tx_take;

  always_comb begin
    wr_ready_o = !out_full_o;
    out_load   = wr_valid_i && !out_full_o;
    tx_valid_o = hid_full_o || (!sync_i && out_full_o);
    tx_data_o  = hid_full_o ? hid_q : out_q;
    tx_take    = tx_valid_o && tx_ready_i;
    hid_unload = tx_take && hid_full_o;
    hid_load   = sync_i && out_full_o && (!hid_full_o || hid_unload);
    out_unload = hid_load || (tx_take && !hid_full_o);
  end

  sbs_hold_stage #(.W(W)) u_out (
    .clk(clk), .rst_n(rst_n), .clr_i(flush_i), .load_i(out_load),
    .unload_i(out_unload), .d_i(wr_data_i), .full_o(out_full_o), .q_o(out_q)
  );

  sbs_hold_stage #(.W(W)) u_hid (
    .clk(clk), .rst_n(rst_n), .clr_i(flush_i), .load_i(hid_load),
    .unload_i(hid_unload), .d_i(out_q), .full_o(hid_full_o), .q_o(hid_q)
  );

  // R4: the hidden register stays empty while in asynchronous mode
  a_r4_async_hid_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_i && !hid_full_o) |=> !hid_full_o);

  // R5: a waiting byte reaches an empty hidden register on the next edge
  a_r5_handoff: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_i && out_full_o && !hid_full_o && !flush_i) |=> hid_full_o);

  // R6: a held hidden byte is presented and stays put until taken
  a_r6_hid_first: assert property (@(posedge clk) disable iff (!rst_n)
    (hid_full_o && !tx_ready_i && !flush_i) |=> (tx_valid_o && $stable(tx_data_o)));
endmodule

// File: rtl/sbs_rx_path.sv
module sbs_rx_path #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush_i,
  input  logic         sync_i,
  input  logic         rx_valid_i,
  input  logic [W-1:0] rx_data_i,
  output logic         rx_ready_o,
  output logic         rd_valid_o,
  output logic [W-1:0] rd_data_o,
  input  logic         rd_ready_i,
  output logic         in_full_o
);
  logic [W-1:0] in_q;
  logic         in_load, in_unload;

  always_comb begin
    in_load    = !sync_i && rx_valid_i && !in_full_o;
    in_unload  = in_full_o && rd_ready_i;
    rd_valid_o = in_full_o || (sync_i && rx_valid_i);
    rd_data_o  = in_full_o ? in_q : rx_data_i;
    rx_ready_o = sync_i ? (!in_full_o && rd_ready_i) : !in_full_o;
  end

  sbs_hold_stage #(.W(W)) u_in (
    .clk(clk), .rst_n(rst_n), .clr_i(flush_i), .load_i(in_load),
    .unload_i(in_unload), .d_i(rx_data_i), .full_o(in_full_o), .q_o(in_q)
  );

  // R8: synchronous receive never fills the input latch
  a_r8_sync_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_i && !in_full_o) |=> !in_full_o);

  // R7: a latched byte is held steady until popped
  a_r7_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (in_full_o && !rd_ready_i && !flush_i) |=> (rd_valid_o && $stable(rd_data_o)));
endmodule

// File: rtl/scsi_byte_stage.sv
module scsi_byte_stage
  import sbs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_i,
  input  logic              sync_mode_i,
  input  logic              dma_wr_valid_i,
  input  logic [DATA_W-1:0] dma_wr_data_i,
  output logic              dma_wr_ready_o,
  output logic              bus_tx_valid_o,
  output logic [DATA_W-1:0] bus_tx_data_o,
  input  logic              bus_tx_ready_i,
  input  logic              bus_rx_valid_i,
  input  logic [DATA_W-1:0] bus_rx_data_i,
  output logic              bus_rx_ready_o,
  output logic              dma_rd_valid_o,
  output logic [DATA_W-1:0] dma_rd_data_o,
  input  logic              dma_rd_ready_i,
  output logic [STAT_W-1:0] status_o
);
  logic          out_full, hid_full, in_full;
  stage_status_t stat;

  sbs_tx_path #(.W(DATA_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .sync_i(sync_mode_i),
    .wr_valid_i(dma_wr_valid_i), .wr_data_i(dma_wr_data_i), .wr_ready_o(dma_wr_ready_o),
    .tx_valid_o(bus_tx_valid_o), .tx_data_o(bus_tx_data_o), .tx_ready_i(bus_tx_ready_i),
    .out_full_o(out_full), .hid_full_o(hid_full)
  );

  sbs_rx_path #(.W(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .sync_i(sync_mode_i),
    .rx_valid_i(bus_rx_valid_i), .rx_data_i(bus_rx_data_i), .rx_ready_o(bus_rx_ready_o),
    .rd_valid_o(dma_rd_valid_o), .rd_data_o(dma_rd_data_o), .rd_ready_i(dma_rd_ready_i),
    .in_full_o(in_full)
  );

  always_comb begin
    stat.in_full  = in_full;
    stat.hid_full = hid_full;
    stat.out_full = out_full;
    stat.zero     = '0;
    status_o      = stat;
  end

  // R9: a flush leaves every stage empty
  a_r9_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (status_o == '0));

  // R3: a held output byte is not replaced before it moves on
  a_r3_wr_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[5] && !flush_i && !bus_tx_ready_i && !sync_mode_i) |=> status_o[5]);
endmodule

// File: tb/scsi_byte_stage_tb.sv
module scsi_byte_stage_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       flush, sync, wr_v, tx_rdy, rx_v, rd_rdy;
  logic [7:0] wr_d, rx_d;
  logic       wr_rdy, tx_v, rx_rdy, rd_v;
  logic [7:0] tx_d, rd_d, stat;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // behavioural model state
  bit       m_out_f, m_hid_f, m_in_f;
  bit [7:0] m_out_d, m_hid_d, m_in_d;
  bit [7:0] txq[$];
  bit [7:0] rxq[$];

  always #4 clk = ~clk;

  scsi_byte_stage #(.DATA_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .flush_i(flush), .sync_mode_i(sync),
    .dma_wr_valid_i(wr_v), .dma_wr_data_i(wr_d), .dma_wr_ready_o(wr_rdy),
    .bus_tx_valid_o(tx_v), .bus_tx_data_o(tx_d), .bus_tx_ready_i(tx_rdy),
    .bus_rx_valid_i(rx_v), .bus_rx_data_i(rx_d), .bus_rx_ready_o(rx_rdy),
    .dma_rd_valid_o(rd_v), .dma_rd_data_o(rd_d), .dma_rd_ready_i(rd_rdy),
    .status_o(stat)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    bit       p_tx_v, p_rd_v, p_rx_rdy;
    bit [7:0] p_tx_d, p_rd_d;
    p_tx_v   = m_hid_f || (!sync && m_out_f);
    p_tx_d   = m_hid_f ? m_hid_d : m_out_d;
    p_rd_v   = m_in_f || (sync && rx_v);
    p_rd_d   = m_in_f ? m_in_d : rx_d;
    p_rx_rdy = sync ? (!m_in_f && rd_rdy) : !m_in_f;
    chk("R2", "status", stat, {m_in_f, m_hid_f, m_out_f, 5'b0});
    chk("R3", "wr_ready", wr_rdy, !m_out_f);
    chk(m_hid_f ? "R6" : (sync ? "R5" : "R4"), "tx_valid", tx_v, p_tx_v);
    if (p_tx_v) chk(m_hid_f ? "R6" : "R4", "tx_data", tx_d, p_tx_d);
    chk(sync ? "R8" : "R7", "rx_ready", rx_rdy, p_rx_rdy);
    chk(sync ? "R8" : "R7", "rd_valid", rd_v, p_rd_v);
    if (p_rd_v) chk(m_in_f ? "R7" : "R8", "rd_data", rd_d, p_rd_d);
    // R10 ordering against queues filled at the inputs
    if (tx_v && tx_rdy && txq.size() > 0) chk("R10", "tx order", tx_d, txq[0]);
    if (rd_v && rd_rdy && rxq.size() > 0) chk("R10", "rx order", rd_d, rxq[0]);
  endtask

  task automatic model_edge();
    bit tx_take, hid_un, hid_ld, out_un, wr_acc, rx_acc, rd_take;
    tx_take = (m_hid_f || (!sync && m_out_f)) && tx_rdy;
    hid_un  = tx_take && m_hid_f;
    hid_ld  = sync && m_out_f && (!m_hid_f || hid_un);
    out_un  = hid_ld || (tx_take && !m_hid_f);
    wr_acc  = wr_v && !m_out_f;
    rx_acc  = rx_v && (sync ? (!m_in_f && rd_rdy) : !m_in_f);
    rd_take = (m_in_f || (sync && rx_v)) && rd_rdy;
    if (tx_take && txq.size() > 0) void'(txq.pop_front());
    if (rd_take && rxq.size() > 0) void'(rxq.pop_front());
    if (flush) begin
      m_out_f = 0; m_hid_f = 0; m_in_f = 0;
      txq.delete();
      // a same-cycle synchronous pass-through still completes
      rxq.delete();
    end else begin
      if (wr_acc) txq.push_back(wr_d);
      if (rx_acc && !sync) rxq.push_back(rx_d);
      if (hid_ld) begin m_hid_f = 1; m_hid_d = m_out_d; end
      else if (hid_un) m_hid_f = 0;
      if (wr_acc) begin m_out_f = 1; m_out_d = wr_d; end
      else if (out_un) m_out_f = 0;
      if (!sync && rx_v && !m_in_f) begin m_in_f = 1; m_in_d = rx_d; end
      else if (m_in_f && rd_rdy) m_in_f = 0;
    end
  endtask

  task automatic step(bit f, bit s, bit wv, bit [7:0] wd, bit tr, bit rv, bit [7:0] rd, bit rr);
    flush = f; sync = s; wr_v = wv; wr_d = wd; tx_rdy = tr; rx_v = rv; rx_d = rd; rd_rdy = rr;
    #1;
    compare_all();
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int sent;
    rst_n = 0;
    flush = 0; sync = 0; wr_v = 0; wr_d = 0; tx_rdy = 0; rx_v = 0; rx_d = 0; rd_rdy = 0;
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk("R1", "status", stat, 0);
    chk("R1", "wr_ready", wr_rdy, 1);
    chk("R1", "tx_valid", tx_v, 0);
    chk("R1", "rd_valid", rd_v, 0);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R4 asynchronous send, with stall
    step(0, 0, 1, 8'hA1, 0, 0, 0, 0);
    step(0, 0, 1, 8'hA2, 0, 0, 0, 0);
    #1 chk("R3", "blocked write kept byte", tx_d, 8'hA1);
    chk("R4", "hidden empty in async", stat[6], 0);
    step(0, 0, 0, 0, 1, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0);

    // R5 fill both sync stages, then release: consecutive sends
    step(0, 1, 1, 8'hB1, 0, 0, 0, 0);
    step(0, 1, 0, 0, 0, 0, 0, 0);
    step(0, 1, 1, 8'hB2, 0, 0, 0, 0);
    #1 chk("R5", "two stages full", stat, 8'h60);
    step(0, 1, 0, 0, 1, 0, 0, 0);
    #1 chk("R5", "back-to-back valid", tx_v, 1);
    chk("R5", "second byte follows", tx_d, 8'hB2);
    chk("R5", "output latch drained", stat[5], 0);
    step(0, 1, 0, 0, 1, 0, 0, 0);

    // R6 hidden byte goes first after switching to async
    step(0, 1, 1, 8'hC1, 0, 0, 0, 0);
    step(0, 1, 0, 0, 0, 0, 0, 0);
    step(0, 0, 1, 8'hC2, 0, 0, 0, 0);
    #1 chk("R6", "hidden byte first", tx_d, 8'hC1);
    step(0, 0, 0, 0, 1, 0, 0, 0);
    #1 chk("R6", "then latch byte", tx_d, 8'hC2);
    step(0, 0, 0, 0, 1, 0, 0, 0);

    // R7 asynchronous receive with DMA stall
    step(0, 0, 0, 0, 0, 1, 8'hD1, 0);
    step(0, 0, 0, 0, 0, 1, 8'hD2, 0);
    #1 chk("R7", "latch holds first byte", rd_d, 8'hD1);
    chk("R7", "rx_ready low when full", rx_rdy, 0);
    step(0, 0, 0, 0, 0, 0, 0, 1);

    // R8 synchronous pass-through
    step(0, 1, 0, 0, 0, 1, 8'hE5, 1);
    step(0, 1, 0, 0, 0, 1, 8'hE6, 0);
    #1 chk("R8", "input flag clear", stat[7], 0);
    chk("R8", "rx_ready follows rd_ready", rx_rdy, 0);

    // R9 flush with all stages busy and new offers
    step(0, 0, 1, 8'hF1, 0, 1, 8'hF2, 0);
    step(0, 1, 1, 8'hF3, 0, 0, 0, 0);
    step(1, 0, 1, 8'hF4, 0, 1, 8'hF5, 0);
    #1 chk("R9", "status after flush", stat, 0);
    chk("R9", "no tx after flush", tx_v, 0);

    // mixed traffic, compared every cycle
    sent = 0;
    for (int i = 0; i < 4000; i++) begin
      bit s;
      s = (i / 300) % 2 == 1;
      if (($urandom % 97) == 0) s = !s;
      step(($urandom % 211) == 0, s, $urandom % 3 != 0, 8'($urandom),
           $urandom % 2 == 0, $urandom % 2 == 0, 8'($urandom), $urandom % 3 != 0);
      if (tx_v) sent++;
    end
    chk("R10", "traffic flowed", int'(sent > 100), 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule